// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement and Unified Recovery

This block keeps the program order of in-flight operations in a small circular queue. The front end claims one slot per operation in issue order and receives the slot number as a tag. Execution units then report results by tag, in any order. The block retires only the oldest slot, and only once that slot has a result. Retiring a slot either writes its value to the register file or releases its store data to memory.

Traps and wrong branch guesses use one recovery path, which acts when the faulting or branching slot reaches the oldest position. A faulting slot does not retire. The whole queue is emptied and the block redirects fetch to a fixed handler vector. A mispredicted branch does retire, and every younger slot is dropped. Fetch is redirected to the branch target when the branch was taken, or to the next sequential address when it was not.

A lookup port lets operand fetch find the youngest in-flight producer of a register. It returns that producer's tag, and also its value once the value is known.

Control is a two-state machine:
- ST_RUN is normal operation.
- ST_RECOVER lasts one cycle after any redirect. During ST_RECOVER allocation is refused while fetch restarts.

There are two transitions:
- "redirect" (ST_RUN to ST_RECOVER) is taken whenever fl_valid is high.
- "resume" (ST_RECOVER to ST_RUN) is taken on the following cycle, unconditionally.

Top module: `rob_core`

## Requirements
- R1: Each accepted allocation returns the slot at the tail as alloc_tag. Successive tags count up by one and wrap from 7 to 0 (depth 8). alloc_ready is low while all 8 slots are live and nothing retires.
- R2: If the buffer is full and the oldest slot retires in the same cycle, alloc_ready is high and the new allocation is accepted into the freed slot.
- R3: A completion writes its value into the slot named by cpl_tag; completions may arrive in any order. Retirement happens only at the oldest slot, and only once that slot is complete. It takes one slot per cycle, in allocation order. For a slot allocated with alloc_wr=1 and no store flag, retirement asserts cm_valid and cm_reg_we, with cm_reg equal to the destination and cm_value equal to the result.
- R4: A slot allocated with alloc_store=1 retires with cm_valid=1, cm_store=1, cm_reg_we=0 and cm_value equal to its completed data.
- R5: When the oldest slot is complete with cpl_exc=1, it does not retire (cm_valid=0). In that cycle fl_valid=1, fl_exc=1, fl_pc equals the TRAP_VEC parameter (default 0x80), fl_cause equals the reported cause and cm_pc equals the faulting slot's PC. Every other slot is discarded without retiring, and the next allocation receives the faulting slot's tag.
- R6: A branch whose reported direction differs from its predicted one retires with cm_valid=1 and cm_reg_we=0. In that cycle fl_valid=1 and fl_exc=0. fl_pc is the reported target if the branch was taken, or its PC plus 4 if not. All younger slots are discarded, lookups no longer find them, and the next allocation gets the tag after the branch.
- R7: A branch whose direction matches its prediction retires with cm_valid=1 and fl_valid=0.
- R8: lk_hit reports the youngest live slot whose destination equals lk_reg and which writes a register, with that slot in lk_tag. lk_ready and lk_value give its result once it is complete. lk_hit=0 means the operand is taken from the architectural register file.
- R9: In the cycle after any redirect, alloc_ready is 0. It returns to 1 on the next cycle.
- R10: After reset the buffer is empty: alloc_ready=1, alloc_tag=0, cm_valid=0, fl_valid=0, lk_hit=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alloc_valid | input | 1 | Request to claim a slot |
| alloc_pc | input | 32 | PC of the operation |
| alloc_dst | input | 5 | Destination register |
| alloc_wr | input | 1 | Operation writes a register |
| alloc_branch | input | 1 | Operation is a branch |
| alloc_pred | input | 1 | Predicted branch direction (1 = taken) |
| alloc_store | input | 1 | Operation is a store |
| alloc_ready | output | 1 | A slot can be claimed this cycle |
| alloc_tag | output | 3 | Slot number given to the operation |
| cpl_valid | input | 1 | Completion report |
| cpl_tag | input | 3 | Slot being completed |
| cpl_value | input | 32 | Result or store data |
| cpl_exc | input | 1 | Operation faulted |
| cpl_cause | input | 4 | Fault cause code |
| cpl_taken | input | 1 | Resolved branch direction |
| cpl_target | input | 32 | Resolved branch target |
| lk_reg | input | 5 | Register being looked up |
| lk_hit | output | 1 | An in-flight producer exists |
| lk_ready | output | 1 | Producer value is available |
| lk_tag | output | 3 | Slot of the youngest producer |
| lk_value | output | 32 | Producer value |
| cm_valid | output | 1 | Oldest slot retires this cycle |
| cm_reg_we | output | 1 | Register-file write enable |
| cm_reg | output | 5 | Register written |
| cm_value | output | 32 | Value written or store data |
| cm_store | output | 1 | Release store data to memory |
| cm_pc | output | 32 | PC of the oldest slot (fault PC on a trap) |
| fl_valid | output | 1 | Redirect this cycle |
| fl_exc | output | 1 | Redirect is a trap |
| fl_pc | output | 32 | Redirect address |
| fl_cause | output | 4 | Trap cause |

## Verification
The hardest case to reach is a retirement and an allocation in the same cycle on a completely full buffer, with the tail wrapped onto the head. The stimulus fills all eight slots and completes them youngest first, so that nothing can retire. It then completes the oldest slot, and allocates again in the first cycle that slot retires. The trap and mispredict paths are reached the same way. Slots behind the faulting or branching slot are completed first, so that they would retire if recovery failed to discard them. Their absence is then checked on cm_valid, on lk_hit and on the next alloc_tag.

// File: rtl/rob_pkg.sv
package rob_pkg;
    parameter int unsigned PC_W    = 32;
    parameter int unsigned REG_W   = 5;
    parameter int unsigned DATA_W  = 32;
    parameter int unsigned CAUSE_W = 4;

    typedef struct packed {
        logic               valid;
        logic               done;
        logic               wr;
        logic               branch;
        logic               pred;
        logic               taken;
        logic               store;
        logic               exc;
        logic [CAUSE_W-1:0] cause;
        logic [REG_W-1:0]   dst;
        logic [PC_W-1:0]    pc;
        logic [PC_W-1:0]    target;
        logic [DATA_W-1:0]  value;
    } rob_entry_t;

    typedef enum logic [0:0] {
        ST_RUN     = 1'b0,
        ST_RECOVER = 1'b1
    } ret_state_t;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned TAG_W = $clog2(DEPTH),
    localparam int unsigned PTR_W = TAG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush_exc,
    input  logic             flush_br,
    output logic [TAG_W-1:0] head_idx,
    output logic [TAG_W-1:0] tail_idx,
    output logic             full
);
    logic [PTR_W-1:0] head_q, tail_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (flush_exc) begin
            tail_q <= head_q;
        end else if (flush_br) begin
            head_q <= head_q + PTR_W'(1);
            tail_q <= head_q + PTR_W'(1);
        end else begin
            if (pop)  head_q <= head_q + PTR_W'(1);
            if (push) tail_q <= tail_q + PTR_W'(1);
        end
    end

    assign head_idx = head_q[TAG_W-1:0];
    assign tail_idx = tail_q[TAG_W-1:0];
    assign full     = (head_q[TAG_W] != tail_q[TAG_W]) &&
                      (head_q[TAG_W-1:0] == tail_q[TAG_W-1:0]);

    // R1: no allocation into a full buffer unless a slot frees the same cycle
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));

    // R5: a trap leaves the buffer empty
    p_trap_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_exc |=> (head_q == tail_q));

    // R6: a mispredict retires the branch and drops everything behind it
    p_br_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_br |=> (head_q == tail_q && head_q == $past(head_q) + PTR_W'(1)));
endmodule

// File: rtl/rob_fwd.sv
module rob_fwd
    import rob_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned TAG_W = $clog2(DEPTH)
) (
    input  logic [TAG_W-1:0]  head_idx,
    input  logic [DEPTH-1:0]  slot_match,
    input  logic [DEPTH-1:0]  slot_done,
    input  logic [DATA_W-1:0] slot_value [DEPTH],
    output logic              hit,
    output logic              ready,
    output logic [TAG_W-1:0]  tag,
    output logic [DATA_W-1:0] value
);
    logic [TAG_W-1:0] pos;

    // Scan oldest to youngest; a later match overrides, so the youngest wins.
    always_comb begin
        hit   = 1'b0;
        ready = 1'b0;
        tag   = '0;
        value = '0;
        pos   = head_idx;
        for (int k = 0; k < DEPTH; k++) begin
            pos = head_idx + TAG_W'(k);
            if (slot_match[pos]) begin
                hit   = 1'b1;
                tag   = pos;
                ready = slot_done[pos];
                value = slot_value[pos];
            end
        end
    end
endmodule

// File: rtl/rob_retire.sv
module rob_retire
    import rob_pkg::*;
#(
    parameter logic [PC_W-1:0] TRAP_VEC = 32'h0000_0080
) (
    input  logic               clk,
    input  logic               rst_n,
    input  rob_entry_t         head,
    output logic               pop,
    output logic               flush_exc,
    output logic               flush_br,
    output logic               alloc_ok,
    output logic               cm_valid,
    output logic               cm_reg_we,
    output logic [REG_W-1:0]   cm_reg,
    output logic [DATA_W-1:0]  cm_value,
    output logic               cm_store,
    output logic [PC_W-1:0]    cm_pc,
    output logic               fl_valid,
    output logic               fl_exc,
    output logic [PC_W-1:0]    fl_pc,
    output logic [CAUSE_W-1:0] fl_cause
);
    ret_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        pop       = 1'b0;
        flush_exc = 1'b0;
        flush_br  = 1'b0;
        alloc_ok  = 1'b0;
        cm_valid  = 1'b0;
        cm_reg_we = 1'b0;
        cm_store  = 1'b0;
        fl_valid  = 1'b0;
        fl_exc    = 1'b0;
        fl_pc     = '0;
        cm_reg    = head.dst;
        cm_value  = head.value;
        cm_pc     = head.pc;
        fl_cause  = head.cause;
        state_d   = ST_RUN;
        unique case (state_q)
            ST_RUN: begin
                alloc_ok = 1'b1;
                if (head.valid && head.done) begin
                    if (head.exc) begin
                        flush_exc = 1'b1;
                        fl_valid  = 1'b1;
                        fl_exc    = 1'b1;
                        fl_pc     = TRAP_VEC;
                        alloc_ok  = 1'b0;
                        state_d   = ST_RECOVER;
                    end else begin
                        pop       = 1'b1;
                        cm_valid  = 1'b1;
                        cm_reg_we = head.wr && !head.store;
                        cm_store  = head.store;
                        if (head.branch && (head.taken != head.pred)) begin
                            flush_br = 1'b1;
                            fl_valid = 1'b1;
                            fl_pc    = head.taken ? head.target
                                                  : head.pc + PC_W'(4);
                            alloc_ok = 1'b0;
                            state_d  = ST_RECOVER;
                        end
                    end
                end
            end
            ST_RECOVER: begin
                state_d = ST_RUN;
            end
        endcase
    end
endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int unsigned      DEPTH    = 8,
    parameter logic [PC_W-1:0]  TRAP_VEC = 32'h0000_0080,
    localparam int unsigned     TAG_W    = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_valid,
    input  logic [PC_W-1:0]    alloc_pc,
    input  logic [REG_W-1:0]   alloc_dst,
    input  logic               alloc_wr,
    input  logic               alloc_branch,
    input  logic               alloc_pred,
    input  logic               alloc_store,
    output logic               alloc_ready,
    output logic [TAG_W-1:0]   alloc_tag,
    input  logic               cpl_valid,
    input  logic [TAG_W-1:0]   cpl_tag,
    input  logic [DATA_W-1:0]  cpl_value,
    input  logic               cpl_exc,
    input  logic [CAUSE_W-1:0] cpl_cause,
    input  logic               cpl_taken,
    input  logic [PC_W-1:0]    cpl_target,
    input  logic [REG_W-1:0]   lk_reg,
    output logic               lk_hit,
    output logic               lk_ready,
    output logic [TAG_W-1:0]   lk_tag,
    output logic [DATA_W-1:0]  lk_value,
    output logic               cm_valid,
    output logic               cm_reg_we,
    output logic [REG_W-1:0]   cm_reg,
    output logic [DATA_W-1:0]  cm_value,
    output logic               cm_store,
    output logic [PC_W-1:0]    cm_pc,
    output logic               fl_valid,
    output logic               fl_exc,
    output logic [PC_W-1:0]    fl_pc,
    output logic [CAUSE_W-1:0] fl_cause
);
    rob_entry_t        ent_vec [DEPTH];
    rob_entry_t        head_ent;
    rob_entry_t        new_ent;
    logic [TAG_W-1:0]  head_idx, tail_idx;
    logic              full, pop, push, flush_exc, flush_br, flush_any, alloc_ok;
    logic [DEPTH-1:0]  slot_match, slot_done;
    logic [DATA_W-1:0] slot_value [DEPTH];

    assign alloc_ready = alloc_ok && (!full || pop);
    assign push        = alloc_valid && alloc_ready;
    assign alloc_tag   = tail_idx;
    assign flush_any   = flush_exc || flush_br;
    assign head_ent    = ent_vec[head_idx];

    always_comb begin
        new_ent        = '0;
        new_ent.valid  = 1'b1;
        new_ent.wr     = alloc_wr;
        new_ent.branch = alloc_branch;
        new_ent.pred   = alloc_pred;
        new_ent.store  = alloc_store;
        new_ent.dst    = alloc_dst;
        new_ent.pc     = alloc_pc;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rob_entry_t slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (flush_any) begin
                slot_q.valid <= 1'b0;
            end else begin
                if (pop && head_idx == TAG_W'(i))
                    slot_q.valid <= 1'b0;
                if (cpl_valid && cpl_tag == TAG_W'(i) && slot_q.valid) begin
                    slot_q.done   <= 1'b1;
                    slot_q.value  <= cpl_value;
                    slot_q.exc    <= cpl_exc;
                    slot_q.cause  <= cpl_cause;
                    slot_q.taken  <= cpl_taken;
                    slot_q.target <= cpl_target;
                end
                if (push && tail_idx == TAG_W'(i))
                    slot_q <= new_ent;
            end
        end

        assign ent_vec[i]    = slot_q;
        assign slot_match[i] = slot_q.valid && slot_q.wr && !slot_q.store &&
                               (slot_q.dst == lk_reg);
        assign slot_done[i]  = slot_q.done;
        assign slot_value[i] = slot_q.value;
    end

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .flush_exc (flush_exc),
        .flush_br  (flush_br),
        .head_idx  (head_idx),
        .tail_idx  (tail_idx),
        .full      (full)
    );

    rob_fwd #(.DEPTH(DEPTH)) u_fwd (
        .head_idx   (head_idx),
        .slot_match (slot_match),
        .slot_done  (slot_done),
        .slot_value (slot_value),
        .hit        (lk_hit),
        .ready      (lk_ready),
        .tag        (lk_tag),
        .value      (lk_value)
    );

    rob_retire #(.TRAP_VEC(TRAP_VEC)) u_retire (
        .clk       (clk),
        .rst_n     (rst_n),
        .head      (head_ent),
        .pop       (pop),
        .flush_exc (flush_exc),
        .flush_br  (flush_br),
        .alloc_ok  (alloc_ok),
        .cm_valid  (cm_valid),
        .cm_reg_we (cm_reg_we),
        .cm_reg    (cm_reg),
        .cm_value  (cm_value),
        .cm_store  (cm_store),
        .cm_pc     (cm_pc),
        .fl_valid  (fl_valid),
        .fl_exc    (fl_exc),
        .fl_pc     (fl_pc),
        .fl_cause  (fl_cause)
    );

    // R9: the cycle after a redirect refuses allocation
    p_recover_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid |=> !alloc_ready);

    // R8: a ready operand always comes with a producer hit
    p_ready_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_ready |-> lk_hit);
endmodule

// File: tb/rob_core_bench.sv
module rob_core_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        alloc_valid, alloc_wr, alloc_branch, alloc_pred, alloc_store;
    logic [31:0] alloc_pc;
    logic [4:0]  alloc_dst;
    logic        alloc_ready;
    logic [2:0]  alloc_tag;
    logic        cpl_valid, cpl_exc, cpl_taken;
    logic [2:0]  cpl_tag;
    logic [31:0] cpl_value, cpl_target;
    logic [3:0]  cpl_cause;
    logic [4:0]  lk_reg;
    logic        lk_hit, lk_ready;
    logic [2:0]  lk_tag;
    logic [31:0] lk_value;
    logic        cm_valid, cm_reg_we, cm_store;
    logic [4:0]  cm_reg;
    logic [31:0] cm_value, cm_pc;
    logic        fl_valid, fl_exc;
    logic [31:0] fl_pc;
    logic [3:0]  fl_cause;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rob_core u_rob_core (.*);

    // {destination, result}; rows 2 and 5 share destination 7
    localparam logic [36:0] VEC [8] = '{
        {5'd1, 32'h0000_1111}, {5'd2, 32'h0000_2222},
        {5'd7, 32'h0000_3333}, {5'd3, 32'h0000_4444},
        {5'd4, 32'h0000_5555}, {5'd7, 32'h0000_6666},
        {5'd5, 32'h0000_7777}, {5'd6, 32'h0000_8888}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; alloc_wr = 0; alloc_branch = 0; alloc_pred = 0;
        alloc_store = 0; alloc_pc = 0; alloc_dst = 0;
        cpl_valid = 0; cpl_exc = 0; cpl_taken = 0; cpl_tag = 0;
        cpl_value = 0; cpl_target = 0; cpl_cause = 0;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic alloc_one(input logic [31:0] pc, input logic [4:0] dst, input logic wr,
                             input logic br, input logic pred, input logic st,
                             input logic [2:0] exp_tag, input string req);
        @(negedge clk);
        idle();
        alloc_valid = 1; alloc_pc = pc; alloc_dst = dst; alloc_wr = wr;
        alloc_branch = br; alloc_pred = pred; alloc_store = st;
        #1;
        chk({req, " alloc_ready"}, 32'(alloc_ready), 32'd1);
        chk({req, " alloc_tag"}, 32'(alloc_tag), 32'(exp_tag));
    endtask

    task automatic cpl_one(input logic [2:0] tag, input logic [31:0] val, input logic exc,
                           input logic [3:0] cause, input logic taken, input logic [31:0] tgt);
        @(negedge clk);
        idle();
        cpl_valid = 1; cpl_tag = tag; cpl_value = val; cpl_exc = exc;
        cpl_cause = cause; cpl_taken = taken; cpl_target = tgt;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle();
        lk_reg = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R10 reset state
        chk("R10 alloc_ready", 32'(alloc_ready), 32'd1);
        chk("R10 alloc_tag", 32'(alloc_tag), 32'd0);
        chk("R10 cm_valid", 32'(cm_valid), 32'd0);
        chk("R10 fl_valid", 32'(fl_valid), 32'd0);
        chk("R10 lk_hit", 32'(lk_hit), 32'd0);

        // R1: fill all eight slots from the table
        for (int i = 0; i < 8; i++)
            alloc_one(32'h100 + 32'(4 * i), VEC[i][36:32], 1, 0, 0, 0, 3'(i), "R1");
        step();
        chk("R1 full blocks", 32'(alloc_ready), 32'd0);

        // R8: youngest producer of r7 is slot 5, not yet ready
        lk_reg = 7;
        #1;
        chk("R8 hit", 32'(lk_hit), 32'd1);
        chk("R8 youngest tag", 32'(lk_tag), 32'd5);
        chk("R8 not ready", 32'(lk_ready), 32'd0);
        lk_reg = 30;
        #1;
        chk("R8 miss to arch file", 32'(lk_hit), 32'd0);

        // R3: complete youngest first; oldest not done, nothing retires
        for (int t = 7; t >= 1; t--) begin
            cpl_one(3'(t), VEC[t][31:0], 0, 0, 0, 0);
            chk("R3 waits for head", 32'(cm_valid), 32'd0);
        end
        lk_reg = 7;
        cpl_one(3'd0, VEC[0][31:0], 0, 0, 0, 0);
        chk("R8 ready value", lk_value, VEC[5][31:0]);
        chk("R8 ready flag", 32'(lk_ready), 32'd1);

        // R3 in-order retirement; R2 allocate while full and retiring
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            idle();
            if (i == 0) begin
                alloc_valid = 1; alloc_pc = 32'h200; alloc_dst = 9; alloc_wr = 1;
            end
            #1;
            if (i == 0) begin
                chk("R2 ready when full and retiring", 32'(alloc_ready), 32'd1);
                chk("R2 tag reuses freed slot", 32'(alloc_tag), 32'd0);
            end
            chk("R3 cm_valid", 32'(cm_valid), 32'd1);
            chk("R3 cm_reg_we", 32'(cm_reg_we), 32'd1);
            chk("R3 cm_reg", 32'(cm_reg), 32'(VEC[i][36:32]));
            chk("R3 cm_value", cm_value, VEC[i][31:0]);
        end
        step();
        chk("R3 idle on incomplete head", 32'(cm_valid), 32'd0);

        // Store, correct branch, faulting op, younger op
        alloc_one(32'h300, 5'd0, 0, 0, 0, 1, 3'd1, "R4");
        alloc_one(32'h304, 5'd0, 0, 1, 1, 0, 3'd2, "R7");
        alloc_one(32'h308, 5'd4, 1, 0, 0, 0, 3'd3, "R5");
        alloc_one(32'h30C, 5'd5, 1, 0, 0, 0, 3'd4, "R5");
        cpl_one(3'd4, 32'h0000_0044, 0, 0, 0, 0);
        cpl_one(3'd3, 32'h0, 1, 4'd6, 0, 0);
        cpl_one(3'd2, 32'h0, 0, 0, 1, 32'h400);
        cpl_one(3'd1, 32'h0000_ABCD, 0, 0, 0, 0);
        chk("R3 no retire before head done", 32'(cm_valid), 32'd0);
        cpl_one(3'd0, 32'h0000_0055, 0, 0, 0, 0);
        step();
        chk("R3 reg commit", 32'(cm_reg), 32'd9);
        chk("R3 reg value", cm_value, 32'h55);
        step();
        chk("R4 cm_store", 32'(cm_store), 32'd1);
        chk("R4 no reg write", 32'(cm_reg_we), 32'd0);
        chk("R4 store data", cm_value, 32'hABCD);
        step();
        chk("R7 branch retires", 32'(cm_valid), 32'd1);
        chk("R7 no redirect", 32'(fl_valid), 32'd0);
        step();
        chk("R5 no retire", 32'(cm_valid), 32'd0);
        chk("R5 fl_valid", 32'(fl_valid), 32'd1);
        chk("R5 fl_exc", 32'(fl_exc), 32'd1);
        chk("R5 vector", fl_pc, 32'h80);
        chk("R5 cause", 32'(fl_cause), 32'd6);
        chk("R5 fault pc", cm_pc, 32'h308);
        step();
        chk("R9 recover blocks alloc", 32'(alloc_ready), 32'd0);
        chk("R5 younger discarded", 32'(cm_valid), 32'd0);
        step();
        chk("R9 resume", 32'(alloc_ready), 32'd1);
        chk("R5 tail back to fault slot", 32'(alloc_tag), 32'd3);
        chk("R5 nothing left", 32'(cm_valid), 32'd0);

        // R6 taken mispredict
        alloc_one(32'h500, 5'd0, 0, 1, 0, 0, 3'd3, "R6");
        alloc_one(32'h504, 5'd6, 1, 0, 0, 0, 3'd4, "R6");
        cpl_one(3'd4, 32'h0000_0066, 0, 0, 0, 0);
        lk_reg = 6;
        cpl_one(3'd3, 32'h0, 0, 0, 1, 32'h800);
        chk("R8 younger value forwarded", lk_value, 32'h66);
        step();
        chk("R6 branch retires", 32'(cm_valid), 32'd1);
        chk("R6 no reg write", 32'(cm_reg_we), 32'd0);
        chk("R6 redirect", 32'(fl_valid), 32'd1);
        chk("R6 not a trap", 32'(fl_exc), 32'd0);
        chk("R6 taken target", fl_pc, 32'h800);
        step();
        chk("R9 recover after mispredict", 32'(alloc_ready), 32'd0);
        chk("R6 younger gone from lookup", 32'(lk_hit), 32'd0);
        step();
        chk("R6 tag after branch", 32'(alloc_tag), 32'd4);

        // R6 not-taken mispredict
        alloc_one(32'h600, 5'd0, 0, 1, 1, 0, 3'd4, "R6");
        cpl_one(3'd4, 32'h0, 0, 0, 0, 32'h900);
        step();
        chk("R6 fallthrough redirect", fl_pc, 32'h604);
        chk("R6 fallthrough retires", 32'(cm_valid), 32'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule